// File: doc/BRIEF.md
# SDR SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of one single-rank SDR SDRAM whenever the memory is not being accessed. After reset it brings the device up in the mandatory order: a long NOP pause, one precharge of all banks, a burst of auto refresh cycles, and a mode register load. After that it keeps the array refreshed and handles self-refresh entry and exit. All timing limits are parameters in clock cycles. The pause length is derived from the clock frequency in MHz and the pause time in microseconds.

An external access arbiter raises `acc_req_i` when it wants the bus. The sequencer answers with `acc_gnt_o` only while it is idle. While the arbiter holds the bus, refresh is deferred. When refresh falls a full interval behind, the sequencer catches up with two back-to-back refreshes as soon as the bus is released. A self-refresh request is honoured only from idle, with no access and no refresh pending. Leaving self refresh raises CKE. The device then stays not ready for two clocks plus one tRC.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is low, and for at least PAUSE_US*CLK_MHZ cycles after its release, the pins carry NOP with CKE high, and `ready_o` and `acc_gnt_o` are low. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1.
- R2: After the pause, exactly one PRECHARGE ALL is issued (cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 high). The first refresh follows exactly T_RP cycles later.
- R3: During initialization, INIT_REFS (default 8) AUTO REFRESH commands are issued with CKE high, each exactly T_RC cycles after the previous one. AUTO REFRESH is cs_n=0, ras_n=0, cas_n=0, we_n=1.
- R4: MODE REGISTER SET (all four command pins low, address = MODE_VAL) is issued exactly T_RC cycles after the last initial refresh. `ready_o` rises exactly T_MRD cycles after it.
- R5: Once initialized, a refresh is requested every T_REFI cycles. A pending refresh waits while `acc_req_i` is high. When the bus is released, a single AUTO REFRESH is issued in the next cycle if only one interval has elapsed.
- R6: If a second interval elapses while a refresh is still pending, two AUTO REFRESH commands are issued exactly T_RC cycles apart after the bus is released, and no third one follows.
- R7: `acc_gnt_o` is high only while idle and `acc_req_i` is high. While a grant is held, only NOP is driven. `ready_o` is low while a refresh is in progress.
- R8: With `sr_req_i` high in idle, no access and no pending refresh, the next cycle carries the AUTO REFRESH encoding with CKE low. CKE then stays low with NOP and `ready_o` low for as long as `sr_req_i` stays high.
- R9: `sr_req_i` has no effect while the arbiter holds a grant: CKE stays high.
- R10: One cycle after `sr_req_i` falls in self refresh, CKE is high. `ready_o` returns exactly T_RC+2 cycles after that, with only NOP in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_req_i | input | 1 | Arbiter wants or holds the bus |
| sr_req_i | input | 1 | Level request to stay in self refresh |
| acc_gnt_o | output | 1 | Bus granted to the arbiter |
| ready_o | output | 1 | Device initialized and idle |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address lines |

## Verification
The bench first runs initialization against a table of expected commands and exact gaps, which separates a wrong order, a missing or extra refresh, and an off-by-one wait. After that the arbiter holds the bus for three different lengths. A short hold or none at all must give one refresh. A hold of more than one interval must also give exactly one. A hold of more than two intervals must give a pair T_RC apart, so the catch-up rule is separated from a plain deferred refresh. Self refresh is requested once during a grant, which must be ignored, and once from idle. The idle request checks the CKE-low entry encoding and the exact exit delay to ready.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_AREF,
    CMD_MRS,
    CMD_SREF
  } cmd_e;

  typedef enum logic [3:0] {
    S_PAUSE,
    S_PALL,
    S_WRP,
    S_AREF,
    S_WRC,
    S_MRS,
    S_WMRD,
    S_IDLE,
    S_SRE,
    S_SR,
    S_SRW,
    S_SRR
  } st_e;

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
  parameter int unsigned T_REFI = 390
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ack_i,
  output logic pend_o,
  output logic over_o
);
  localparam int unsigned RW = $clog2(T_REFI + 1);

  logic [RW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == RW'(T_REFI - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
      over_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
      over_o <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (ack_i) begin
        pend_o <= wrap;
        over_o <= 1'b0;
      end else if (wrap) begin
        pend_o <= 1'b1;
        over_o <= pend_o | over_o;   // second lapse while still pending
      end
    end
  end

  // R6
  overdue_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |-> pend_o);

  // R6
  overdue_needs_prior_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(over_o) |-> $past(pend_o));

endmodule

// File: rtl/sdr_cmd_enc.sv
module sdr_cmd_enc
  import sdr_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
  input  cmd_e              cmd_i,
  input  logic              cke_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] pall_addr;

  // all-bank select bit sits at position 10 when the bus is wide enough
  generate
    if (ADDR_W > 10) begin : g_a10
      assign pall_addr = ADDR_W'(1) << 10;
    end else begin : g_narrow
      assign pall_addr = '1;
    end
  endgenerate

  assign cke_o = cke_i;

  always_comb begin
    {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0111;
    addr_o = '0;
    unique case (cmd_i)
      CMD_PALL: begin
        {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0010;
        addr_o = pall_addr;
      end
      CMD_AREF, CMD_SREF: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0001;
      CMD_MRS: begin
        {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0000;
        addr_o = MODE_VAL;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int unsigned       CLK_MHZ   = 50,
  parameter int unsigned       PAUSE_US  = 100,
  parameter int unsigned       T_RP      = 3,
  parameter int unsigned       T_RC      = 7,
  parameter int unsigned       T_MRD     = 2,
  parameter int unsigned       T_REFI    = 390,
  parameter int unsigned       INIT_REFS = 8,
  parameter int unsigned       ADDR_W    = 13,
  parameter logic [ADDR_W-1:0] MODE_VAL  = 13'h033
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_req_i,
  input  logic              sr_req_i,
  output logic              acc_gnt_o,
  output logic              ready_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int unsigned CNT_W     = $clog2(PAUSE_CYC + T_RC + T_RP + T_MRD + 2);
  localparam int unsigned REFS_W    = $clog2(INIT_REFS + 1);
  localparam int unsigned GAP_W     = $clog2(T_RC + 1);
  // wait state after a one-cycle command lasts load+1 cycles
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] LD_SRR = CNT_W'(T_RC - 1);

  st_e                st_q, st_d;
  cmd_e               cmd;
  logic               cke;
  logic               ld, tmr_zero;
  logic [CNT_W-1:0]   ld_val;
  logic [REFS_W-1:0]  ref_left_q;
  logic               init_done_q;
  logic               pend, over, ack, clr, in_sr;

  sdr_wait_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PAUSE_CYC - 1)
  ) i_wait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .zero_o(tmr_zero)
  );

  sdr_refi_timer #(
    .T_REFI(T_REFI)
  ) i_refi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .ack_i (ack),
    .pend_o(pend),
    .over_o(over)
  );

  sdr_cmd_enc #(
    .ADDR_W  (ADDR_W),
    .MODE_VAL(MODE_VAL)
  ) i_enc (
    .cmd_i  (cmd),
    .cke_i  (cke),
    .cke_o  (cke_o),
    .cs_n_o (cs_n_o),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o),
    .we_n_o (we_n_o),
    .addr_o (addr_o)
  );

  assign in_sr     = (st_q == S_SRE) || (st_q == S_SR) || (st_q == S_SRW) || (st_q == S_SRR);
  assign clr       = !init_done_q || in_sr;
  assign ack       = (st_q == S_IDLE) && !acc_req_i && pend;
  assign ready_o   = (st_q == S_IDLE);
  assign acc_gnt_o = ready_o && acc_req_i;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    cmd    = CMD_NOP;
    cke    = 1'b1;
    unique case (st_q)
      S_PAUSE: if (tmr_zero) st_d = S_PALL;
      S_PALL: begin
        cmd = CMD_PALL; ld = 1'b1; ld_val = LD_RP; st_d = S_WRP;
      end
      S_WRP: if (tmr_zero) st_d = S_AREF;
      S_AREF: begin
        cmd = CMD_AREF; ld = 1'b1; ld_val = LD_RC; st_d = S_WRC;
      end
      S_WRC: if (tmr_zero) begin
        if (ref_left_q != '0)  st_d = S_AREF;
        else if (init_done_q)  st_d = S_IDLE;
        else                   st_d = S_MRS;
      end
      S_MRS: begin
        cmd = CMD_MRS; ld = 1'b1; ld_val = LD_MRD; st_d = S_WMRD;
      end
      S_WMRD: if (tmr_zero) st_d = S_IDLE;
      S_IDLE: begin
        if (acc_req_i)      st_d = S_IDLE;
        else if (pend)      st_d = S_AREF;
        else if (sr_req_i)  st_d = S_SRE;
      end
      S_SRE: begin
        cmd = CMD_SREF; cke = 1'b0; st_d = S_SR;
      end
      S_SR: begin
        cke = 1'b0;
        if (!sr_req_i) begin
          st_d = S_SRW; ld = 1'b1; ld_val = CNT_W'(1);
        end
      end
      S_SRW: if (tmr_zero) begin
        st_d = S_SRR; ld = 1'b1; ld_val = LD_SRR;
      end
      S_SRR: if (tmr_zero) st_d = S_IDLE;
      default: st_d = S_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_PAUSE;
      ref_left_q  <= '0;
      init_done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_MRS) init_done_q <= 1'b1;
      if (st_q == S_PALL)
        ref_left_q <= REFS_W'(INIT_REFS - 1);
      else if (st_q == S_WRC && tmr_zero && ref_left_q != '0)
        ref_left_q <= ref_left_q - 1'b1;
      else if (ack)
        ref_left_q <= over ? REFS_W'(1) : '0;   // catch-up pair
    end
  end

  // ---- checker state and assertions ----
  logic [REFS_W-1:0] refs_seen_q;
  logic [GAP_W-1:0]  gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      refs_seen_q <= '0;
      gap_q       <= GAP_W'(T_RC);
    end else begin
      if (st_q == S_AREF && !init_done_q) refs_seen_q <= refs_seen_q + 1'b1;
      if (st_q == S_AREF)                 gap_q <= GAP_W'(1);
      else if (gap_q != GAP_W'(T_RC))     gap_q <= gap_q + 1'b1;
    end
  end

  // R2
  pall_after_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PALL) |-> ($past(st_q) == S_PAUSE));

  // R3
  init_refs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_MRS) |-> (refs_seen_q == REFS_W'(INIT_REFS)));

  // R6
  ref_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_AREF) |-> (gap_q == GAP_W'(T_RC)));

  // R4
  ready_needs_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> init_done_q);

  // R10
  sr_exit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |=> !ready_o);

  // R7
  gnt_only_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_gnt_o |-> (cs_n_o || (ras_n_o && cas_n_o && we_n_o)));

endmodule

// File: tb/test_sdram_init_refresh_seq.sv
module test_sdram_init_refresh_seq;
  localparam int CLK_MHZ   = 50;
  localparam int PAUSE_US  = 100;
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int T_RP      = 3;
  localparam int T_RC      = 7;
  localparam int T_MRD     = 2;
  localparam int T_REFI    = 390;
  localparam int INIT_REFS = 8;
  localparam int ADDR_W    = 13;
  localparam logic [ADDR_W-1:0] MODE_VAL = 13'h033;

  localparam int C_NOP = 0, C_PRE = 1, C_REF = 2, C_MRS = 3, C_BAD = 4;
  localparam int N_VEC = 10;
  localparam int VEC_CODE [N_VEC] = '{C_PRE, C_REF, C_REF, C_REF, C_REF,
                                      C_REF, C_REF, C_REF, C_REF, C_MRS};
  localparam int VEC_MIN  [N_VEC] = '{PAUSE_CYC, T_RP, T_RC, T_RC, T_RC,
                                      T_RC, T_RC, T_RC, T_RC, T_RC};
  localparam int VEC_MAX  [N_VEC] = '{PAUSE_CYC + 1, T_RP, T_RC, T_RC, T_RC,
                                      T_RC, T_RC, T_RC, T_RC, T_RC};

  logic clk = 1'b0;
  logic rst_ni, acc_req_i, sr_req_i;
  logic acc_gnt_o, ready_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [ADDR_W-1:0] addr_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sdram_init_refresh_seq #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .T_REFI(T_REFI), .INIT_REFS(INIT_REFS),
    .ADDR_W(ADDR_W), .MODE_VAL(MODE_VAL)
  ) i_sdram_init_refresh_seq (
    .clk_i(clk), .rst_ni(rst_ni), .acc_req_i(acc_req_i), .sr_req_i(sr_req_i),
    .acc_gnt_o(acc_gnt_o), .ready_o(ready_o), .cke_o(cke_o), .cs_n_o(cs_n_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o)
  );

  function automatic int decode();
    case ({cs_n_o, ras_n_o, cas_n_o, we_n_o})
      4'b0111: return C_NOP;
      4'b0010: return C_PRE;
      4'b0001: return C_REF;
      4'b0000: return C_MRS;
      default: return C_BAD;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_cmd(output int code, output int gap, output bit rdy_seen);
    code = C_NOP; gap = 0; rdy_seen = 1'b0;
    while (code == C_NOP && gap < 20000) begin
      @(negedge clk);
      gap++;
      code = decode();
      if (ready_o) rdy_seen = 1'b1;
    end
  endtask

  task automatic quiet(input int n, output int cmds);
    cmds = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (decode() != C_NOP || !cke_o) cmds++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int code, gap, n, cmds;
    bit rdy;
    rst_ni = 1'b0; acc_req_i = 1'b0; sr_req_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(decode() == C_NOP && cke_o, "R1", decode(), C_NOP);
    chk(!ready_o && !acc_gnt_o, "R1", ready_o, 0);
    rst_ni = 1'b1;

    // R2 R3 R4 initialization order and gaps from the vector table
    for (int i = 0; i < N_VEC; i++) begin
      string rq;
      rq = (VEC_CODE[i] == C_PRE) ? "R2" : (VEC_CODE[i] == C_REF) ? "R3" : "R4";
      next_cmd(code, gap, rdy);
      chk(code == VEC_CODE[i], rq, code, VEC_CODE[i]);
      chk(gap >= VEC_MIN[i] && gap <= VEC_MAX[i], rq, gap, VEC_MIN[i]);
      chk(cke_o && !rdy, (i == 0) ? "R1" : rq, rdy, 0);
      if (VEC_CODE[i] == C_PRE) chk(addr_o[10] == 1'b1, "R2", addr_o[10], 1);
      if (VEC_CODE[i] == C_MRS) chk(addr_o == MODE_VAL, "R4", addr_o, MODE_VAL);
    end
    n = 0;
    while (!ready_o && n < 100) begin @(negedge clk); n++; end
    chk(n == T_MRD, "R4", n, T_MRD);

    // R5 periodic refresh, released bus
    next_cmd(code, gap, rdy);
    chk(code == C_REF, "R5", code, C_REF);
    chk(gap >= T_REFI - 4 && gap <= T_REFI + 3, "R5", gap, T_REFI);
    chk(!ready_o && !acc_gnt_o, "R7", ready_o, 0);
    quiet(3 * T_RC, cmds);
    chk(cmds == 0, "R5", cmds, 0);

    // R7 R9 long grant, self-refresh request ignored; R6 catch-up
    acc_req_i = 1'b1; sr_req_i = 1'b1;
    @(negedge clk);
    chk(acc_gnt_o == 1'b1, "R7", acc_gnt_o, 1);
    quiet(2 * T_REFI + 30, cmds);
    chk(cmds == 0, "R9", cmds, 0);
    sr_req_i = 1'b0; acc_req_i = 1'b0;
    @(negedge clk);
    chk(acc_gnt_o == 1'b0, "R7", acc_gnt_o, 0);
    chk(decode() == C_REF, "R6", decode(), C_REF);
    next_cmd(code, gap, rdy);
    chk(code == C_REF && gap == T_RC, "R6", gap, T_RC);
    quiet(3 * T_RC, cmds);
    chk(cmds == 0, "R6", cmds, 0);

    // R5 grant held just over one interval: single deferred refresh
    acc_req_i = 1'b1;
    repeat (T_REFI + 20) @(negedge clk);
    acc_req_i = 1'b0;
    next_cmd(code, gap, rdy);
    chk(code == C_REF && gap <= 2, "R5", gap, 1);
    quiet(3 * T_RC, cmds);
    chk(cmds == 0, "R5", cmds, 0);

    // R8 self-refresh entry
    sr_req_i = 1'b1;
    @(negedge clk);
    chk(decode() == C_REF && !cke_o, "R8", cke_o, 0);
    cmds = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cke_o || ready_o || decode() != C_NOP) cmds++;
    end
    chk(cmds == 0, "R8", cmds, 0);

    // R10 self-refresh exit
    sr_req_i = 1'b0;
    @(negedge clk);
    chk(cke_o == 1'b1, "R10", cke_o, 1);
    n = 0; cmds = 0;
    while (!ready_o && n < 200) begin
      @(negedge clk);
      n++;
      if (decode() != C_NOP) cmds++;
    end
    chk(n == T_RC + 2, "R10", n, T_RC + 2);
    chk(cmds == 0, "R10", cmds, 0);

    // R1 asynchronous reset mid-operation
    rst_ni = 1'b0;
    #1;
    chk(!ready_o && cke_o && decode() == C_NOP, "R1", ready_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule